// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit load/store datapath and a data memory port that is one word wide and has a write enable for each byte. It receives a finished byte address, an access size (byte, halfword or word), a byte-order select and a signed/unsigned select. For a store, it drives one write enable per byte lane. It also places the store value so that whichever lanes are enabled hold the right bytes. For a load, it takes the full memory word, picks the addressed byte or halfword and widens it to 32 bits by sign or zero extension.

The unit also checks alignment. A halfword must sit on an even address and a word on an address that is a multiple of four. A misaligned access, or one that uses the reserved size code, raises an error flag for the cycle in which it is presented. That access writes nothing and returns zero load data. The datapath is purely combinational. A single register holds a copy of the error flag one cycle late, so it can be observed next to the clock.

Top module: `mem_lane_steer`

## Requirements
- R1: A word access (size code 2) is misaligned whenever the two low address bits are not both zero.
- R2: A halfword access (size code 1) is misaligned whenever address bit 0 is one.
- R3: A byte access (size code 0) is never misaligned, and the reserved size code 3 is always treated as misaligned.
- R4: While an access is misaligned, all four write enables are low and the load data output is zero.
- R5: `misalign` is high only in a cycle where `req_valid` is high and the access is misaligned. `misalign_q` repeats that value one clock later and is zero in reset.
- R6: In little-endian mode (`big_endian`=0), the byte at address offset o uses lane o, where lane k is bits 8k+7..8k. A halfword at offset o uses lanes o and o+1. A word uses all four lanes.
- R7: In big-endian mode (`big_endian`=1), the byte at offset o uses lane 3-o. A halfword at offset 0 uses lanes 3 and 2, and a halfword at offset 2 uses lanes 1 and 0.
- R8: Store data for a byte is the low byte of `st_data` copied onto all four lanes. For a halfword it is the low 16 bits copied onto both halves. For a word it is `st_data` unchanged.
- R9: A byte load returns the lane chosen by R6 or R7 in bits 7..0.
- R10: A halfword load returns the 16-bit half of the memory word that holds the lanes chosen by R6 or R7, with no byte swap inside it. A word load returns the memory word unchanged in both modes.
- R11: With `ld_signed`=1, a byte or halfword load copies its top bit into all upper bits. With `ld_signed`=0, the upper bits are zero.
- R12: Write enables are all low for a load (`is_store`=0) and whenever `req_valid` is low. Address bits above bit 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered error flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| addr | input | 32 | Finished byte address |
| big_endian | input | 1 | 1 = big-endian byte numbering |
| ld_signed | input | 1 | 1 = sign-extend partial loads |
| st_data | input | 32 | Store value, right-justified |
| mem_rdata | input | 32 | Word read from memory |
| wr_en | output | 4 | Per-lane write enables, bit k for lane k |
| wr_data | output | 32 | Store data placed on the lanes |
| ld_data | output | 32 | Extracted and extended load value |
| misalign | output | 1 | Same-cycle misalignment flag |
| misalign_q | output | 1 | Error flag delayed one clock |

## Verification
All outputs except `misalign_q` settle in the same cycle as the inputs that cause them. The bench drives every vector on a falling edge and reads these outputs one nanosecond later, before the next rising edge. `misalign_q` is due one rising edge after the access. Each time the table loop reaches the next falling edge, it first compares `misalign_q` with the error expected from the previous vector, and only then drives new inputs. The directed tests read the flag in reset and after a masked request in the same way.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;

endpackage

// File: rtl/lsa_align_chk.sv
module lsa_align_chk
   import lsa_pkg::*;
#(
   parameter int OFF_W = 2
) (
   input  acc_size_e        size_i,
   input  logic [OFF_W-1:0] off_i,
   output logic             bad_o
);

   always_comb begin
      unique case (size_i)
         SZ_BYTE: bad_o = 1'b0;
         SZ_HALF: bad_o = off_i[0];
         SZ_WORD: bad_o = |off_i;
         default: bad_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
   import lsa_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / BYTE_W,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic              en_i,
   input  acc_size_e         size_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic              be_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [LANES-1:0]  we_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int HALVES = DATA_W / HALF_W;

   // Enable for each lane: compare the lane's byte address with the offset
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [OFF_W-1:0] pos;
      logic             hit;
      assign pos = be_i ? OFF_W'(LANES - 1 - k) : OFF_W'(k);
      always_comb begin
         unique case (size_i)
            SZ_BYTE: hit = (pos == off_i);
            SZ_HALF: hit = (pos[OFF_W-1:1] == off_i[OFF_W-1:1]);
            SZ_WORD: hit = 1'b1;
            default: hit = 1'b0;
         endcase
      end
      assign we_o[k] = en_i & hit;
   end

   always_comb begin
      unique case (size_i)
         SZ_BYTE: data_o = {LANES{data_i[BYTE_W-1:0]}};
         SZ_HALF: data_o = {HALVES{data_i[HALF_W-1:0]}};
         default: data_o = data_i;
      endcase
   end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
   import lsa_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / BYTE_W,
   localparam int OFF_W = $clog2(LANES),
   localparam int HALVES = DATA_W / HALF_W,
   localparam int HSEL_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
   input  acc_size_e         size_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic              be_i,
   input  logic              sgn_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] data_o
);

   logic [OFF_W-1:0]  bsel;
   logic [HSEL_W-1:0] hsel;
   logic [BYTE_W-1:0] bval;
   logic [HALF_W-1:0] hval;

   assign bsel = be_i ? OFF_W'(LANES - 1) - off_i : off_i;
   assign hsel = be_i ? HSEL_W'(HALVES - 1) - off_i[OFF_W-1:1] : off_i[OFF_W-1:1];
   assign bval = word_i[BYTE_W*bsel +: BYTE_W];
   assign hval = word_i[HALF_W*hsel +: HALF_W];

   always_comb begin
      unique case (size_i)
         SZ_BYTE: data_o = {{(DATA_W-BYTE_W){sgn_i & bval[BYTE_W-1]}}, bval};
         SZ_HALF: data_o = {{(DATA_W-HALF_W){sgn_i & hval[HALF_W-1]}}, hval};
         SZ_WORD: data_o = word_i;
         default: data_o = '0;
      endcase
   end

endmodule

// File: rtl/mem_lane_steer.sv
module mem_lane_steer
   import lsa_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter bit SUPPORT_BE = 1'b1,
   localparam int LANES = DATA_W / BYTE_W,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              is_store,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic              big_endian,
   input  logic              ld_signed,
   input  logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [LANES-1:0]  wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ld_data,
   output logic              misalign,
   output logic              misalign_q
);

   if (DATA_W != 32) begin : g_bad_width
      $error("mem_lane_steer: DATA_W must be 32 for byte/half/word sizes");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("mem_lane_steer: ADDR_W narrower than the lane offset");
   end

   acc_size_e         size_e;
   logic [OFF_W-1:0]  off;
   logic              eff_be;
   logic              bad;
   logic [DATA_W-1:0] ld_raw;
   logic              unused_addr_hi;

   assign size_e         = acc_size_e'(size);
   assign off            = addr[OFF_W-1:0];
   assign unused_addr_hi = ^addr[ADDR_W-1:OFF_W];

   // Byte-order variant chosen at elaboration
   if (SUPPORT_BE) begin : g_be
      assign eff_be = big_endian;
   end else begin : g_le_only
      logic unused_be;
      assign unused_be = big_endian;
      assign eff_be    = 1'b0;
   end

   lsa_align_chk #(.OFF_W(OFF_W)) u_align (
      .size_i (size_e),
      .off_i  (off),
      .bad_o  (bad)
   );

   lsa_store_steer #(.DATA_W(DATA_W)) u_store (
      .en_i   (req_valid & is_store & ~bad),
      .size_i (size_e),
      .off_i  (off),
      .be_i   (eff_be),
      .data_i (st_data),
      .we_o   (wr_en),
      .data_o (wr_data)
   );

   lsa_load_extract #(.DATA_W(DATA_W)) u_load (
      .size_i (size_e),
      .off_i  (off),
      .be_i   (eff_be),
      .sgn_i  (ld_signed),
      .word_i (mem_rdata),
      .data_o (ld_raw)
   );

   assign ld_data  = bad ? '0 : ld_raw;
   assign misalign = req_valid & bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) misalign_q <= 1'b0;
      else        misalign_q <= misalign;
   end

endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              is_store,
   input logic [1:0]        size,
   input logic [OFF_W-1:0]  addr_lo,
   input logic [LANES-1:0]  wr_en,
   input logic [DATA_W-1:0] ld_data,
   input logic              misalign,
   input logic              misalign_q
);

   a_r1_word_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && size == 2'd2 && addr_lo != '0) |-> misalign);

   a_r2_half_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && size == 2'd1 && addr_lo[0]) |-> misalign);

   a_r3_byte_never: assert property (@(posedge clk) disable iff (!rst_n)
      (size == 2'd0) |-> !misalign);

   a_r4_quiet_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (wr_en == '0 && ld_data == '0));

   a_r5_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |=> misalign_q);

   a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !misalign |=> !misalign_q);

   a_r6_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_store && size == 2'd0) |-> $countones(wr_en) == 1);

   a_r7_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && is_store && size == 2'd1 && !misalign) |-> $countones(wr_en) == 2);

   a_r12_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || !is_store) |-> wr_en == '0);

endmodule

bind mem_lane_steer lsa_checker #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .is_store   (is_store),
   .size       (size),
   .addr_lo    (addr[OFF_W-1:0]),
   .wr_en      (wr_en),
   .ld_data    (ld_data),
   .misalign   (misalign),
   .misalign_q (misalign_q)
);

// File: tb/sim_mem_lane_steer.sv
module sim_mem_lane_steer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        is_store = 1'b0;
   logic [1:0]  size = 2'd0;
   logic [31:0] addr = 32'h0;
   logic        big_endian = 1'b0;
   logic        ld_signed = 1'b0;
   logic [31:0] st_data = 32'h1234_A5F6;
   logic [31:0] mem_rdata = 32'h8A7B_C6D5;
   logic [3:0]  wr_en;
   logic [31:0] wr_data;
   logic [31:0] ld_data;
   logic        misalign;
   logic        misalign_q;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   mem_lane_steer u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_store(is_store),
      .size(size), .addr(addr), .big_endian(big_endian), .ld_signed(ld_signed),
      .st_data(st_data), .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_data(wr_data),
      .ld_data(ld_data), .misalign(misalign), .misalign_q(misalign_q)
   );

   // {store, size, offset, big_endian, signed, exp_we, exp_data, exp_err}
   localparam int NV = 23;
   localparam logic [43:0] VEC [NV] = '{
      {1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'h0, 32'hFFFF_FFD5, 1'b0},
      {1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 4'h0, 32'h0000_00C6, 1'b0},
      {1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 4'h0, 32'h0000_008A, 1'b0},
      {1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 4'h0, 32'hFFFF_FFC6, 1'b0},
      {1'b0, 2'd0, 2'd1, 1'b1, 1'b1, 4'h0, 32'h0000_007B, 1'b0},
      {1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 4'h0, 32'hFFFF_C6D5, 1'b0},
      {1'b0, 2'd1, 2'd2, 1'b0, 1'b1, 4'h0, 32'hFFFF_8A7B, 1'b0},
      {1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 4'h0, 32'h0000_8A7B, 1'b0},
      {1'b0, 2'd1, 2'd0, 1'b1, 1'b0, 4'h0, 32'h0000_8A7B, 1'b0},
      {1'b0, 2'd1, 2'd2, 1'b1, 1'b1, 4'h0, 32'hFFFF_C6D5, 1'b0},
      {1'b0, 2'd2, 2'd0, 1'b1, 1'b1, 4'h0, 32'h8A7B_C6D5, 1'b0},
      {1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 4'h0, 32'h0000_0000, 1'b1},
      {1'b0, 2'd2, 2'd2, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 1'b1},
      {1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 4'h4, 32'hF6F6_F6F6, 1'b0},
      {1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 4'h2, 32'hF6F6_F6F6, 1'b0},
      {1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 4'hC, 32'hA5F6_A5F6, 1'b0},
      {1'b1, 2'd1, 2'd2, 1'b0, 1'b0, 4'hC, 32'hA5F6_A5F6, 1'b0},
      {1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 4'h3, 32'hA5F6_A5F6, 1'b0},
      {1'b1, 2'd2, 2'd0, 1'b1, 1'b0, 4'hF, 32'h1234_A5F6, 1'b0},
      {1'b1, 2'd2, 2'd1, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 1'b1},
      {1'b1, 2'd1, 2'd3, 1'b1, 1'b0, 4'h0, 32'h0000_0000, 1'b1},
      {1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 1'b1},
      {1'b0, 2'd0, 2'd3, 1'b0, 1'b1, 4'h0, 32'hFFFF_FF8A, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      #(8 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic prev_err;
      prev_err = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 reset flag", {31'b0, misalign_q}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [43:0] v;
         v = VEC[i];
         @(negedge clk);
         if (i > 0) chk("R5 delayed flag", {31'b0, misalign_q}, {31'b0, prev_err});
         req_valid  = 1'b1;
         is_store   = v[43];
         size       = v[42:41];
         addr       = 32'h0000_1000 | {30'b0, v[40:39]};
         big_endian = v[38];
         ld_signed  = v[37];
         #1;
         chk("R1 R2 R3 flag", {31'b0, misalign}, {31'b0, v[0]});
         if (v[0]) begin
            chk("R4 enables on error", {28'b0, wr_en}, 32'h0);
            chk("R4 load zero on error", ld_data, 32'h0);
         end else if (v[43]) begin
            chk("R6 R7 enables", {28'b0, wr_en}, {28'b0, v[36:33]});
            chk("R8 store data", wr_data, v[32:1]);
         end else begin
            chk("R9 R10 R11 load data", ld_data, v[32:1]);
            chk("R12 load no write", {28'b0, wr_en}, 32'h0);
         end
         prev_err = v[0];
      end

      // R5: a masked misaligned request raises no flag and writes nothing
      @(negedge clk);
      chk("R5 delayed flag", {31'b0, misalign_q}, {31'b0, prev_err});
      req_valid = 1'b0; is_store = 1'b1; size = 2'd2; addr = 32'h0000_2001;
      #1;
      chk("R5 masked flag", {31'b0, misalign}, 32'h0);
      chk("R12 masked enables", {28'b0, wr_en}, 32'h0);
      @(negedge clk);
      chk("R5 masked delayed flag", {31'b0, misalign_q}, 32'h0);

      // R12: upper address bits do not change lane choice
      req_valid = 1'b1; is_store = 1'b1; size = 2'd0; big_endian = 1'b1;
      addr = 32'hFFFF_FFF2;
      #1;
      chk("R12 high address bits", {28'b0, wr_en}, 32'h2);
      chk("R8 byte copy", wr_data, 32'hF6F6_F6F6);

      // R3: misaligned word raises flag, next cycle registered, then clears
      @(negedge clk);
      size = 2'd2; addr = 32'h0000_0003;
      #1;
      chk("R1 word off3", {31'b0, misalign}, 32'h1);
      @(negedge clk);
      chk("R5 flag after error", {31'b0, misalign_q}, 32'h1);
      size = 2'd0;
      #1;
      chk("R3 byte off3 aligned", {31'b0, misalign}, 32'h0);
      @(negedge clk);
      chk("R5 flag cleared", {31'b0, misalign_q}, 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule